// File: doc/BRIEF.md
# Multicore Global Control Registers

This block is a memory-mapped register file shared by a cluster of processor cores. A single-cycle register bus carries an address, write data, a write strobe, a read strobe and the identifier of the core that issues the access. The address space holds one global section and two per-core windows.

The global section reports cluster-wide facts: configuration, revision, block base, cache bypass state and the presence of two attached subordinate regions, an interrupt controller and a power controller. It also holds a base register for each subordinate, which drives out a region base address and an enable.

The local window lands on the requesting core's own slot. The "other" window lands on the slot of whichever core the requester's own selector currently names. Each slot holds a reset-base register that drives that core's exception vector and a selector that points at another core.

Top module: `mcgr_top`

## Requirements
- R1: The global configuration register (global offset 0x000) reads zero. Reads at unmapped offsets return zero, and writes to them change no register or output.
- R2: The per-core configuration register (window offset 0x010) reads NCORES-1 through both the local and the other window.
- R3: A write to a selector register (window offset 0x018) takes effect only when wdata[SEL_W-1:0] is below NCORES; the stored value is those masked bits. Any other write leaves the selector unchanged.
- R4: Window 0x2 (address bits 15:12) reaches the requester's own slot. Window 0x4 reaches the slot named by the requester's selector. Both the reset base (window offset 0x020) and the selector can be read and written through either window.
- R5: After reset every selector reads 0, every reset base reads 0xBFC00000 under the mask 0xFFFFF000, and every exception vector is 0xFFFFFFFF_BFC00000.
- R6: A core's exception vector equals its reset base, masked to bits 31:12 and sign-extended from bit 31 to 64 bits. It changes in the clock cycle that follows the write.
- R7: A write to a subordinate base register (interrupt controller 0x080, power controller 0x088) stores wdata & 0xFFFF8001, and only when that subordinate's present input is high. The region base output is bits 31:15 of the stored value and the region enable output is bit 0.
- R8: The status registers (0x0D0 interrupt controller, 0x0F0 power controller) read 1 when the subordinate is present and 0 when it is absent. A base register reads back its stored masked value.
- R9: The cache configuration register (0x130) reads with only bit 20 set. The revision register (0x030) reads parameter REV (default 0x800), and the block base register (0x008) reads parameter BLK_BASE (default 0x1FBF8000).
- R10: Reset clears both subordinate base registers, so both region base outputs and both enables read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 16 | Byte address of the access |
| wdata_i | input | 64 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| req_id_i | input | 2 | Identifier of the requesting core |
| rdata_o | output | 64 | Read data, valid in the same cycle as rd_en_i, zero otherwise |
| vec_o | output | 256 | Exception vectors, core i at bits i*64 +: 64 |
| ic_present_i | input | 1 | Interrupt controller is attached |
| pc_present_i | input | 1 | Power controller is attached |
| ic_base_o | output | 64 | Interrupt controller region base |
| ic_en_o | output | 1 | Interrupt controller region enable |
| pc_base_o | output | 64 | Power controller region base |
| pc_en_o | output | 1 | Power controller region enable |

## Verification
The bench uses the default parameters: four cores, 64-bit data and a 4-bit selector field. Selector values 4 to 15 are therefore out of range, and a value such as 0x13 shows that bits above the field are masked off before the range check. With four slots the bench can chain selectors across cores, so an other-window write lands on a slot different from both the requester's slot and core 0. The present inputs are driven high and low from the bench, which exercises both the gated and the accepted base-register writes.

// File: rtl/mcgr_pkg.sv
package mcgr_pkg;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_GLOBAL,
        WIN_LOCAL,
        WIN_OTHER
    } win_e;

    function automatic logic [63:0] sext32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

endpackage

// File: rtl/mcgr_core_slot.sv
module mcgr_core_slot #(
    parameter int          DW       = 64,
    parameter int          NCORES   = 4,
    parameter int          IDX_W    = 2,
    parameter int          SEL_W    = 4,
    parameter logic [31:0] RB_MASK  = 32'hFFFF_F000,
    parameter logic [31:0] RB_RESET = 32'hBFC0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we_i,
    input  logic             rb_we_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [IDX_W-1:0] sel_o,
    output logic [31:0]      rbase_o,
    output logic [DW-1:0]    vec_o
);
    localparam logic [SEL_W:0] NC = (SEL_W+1)'(NCORES);

    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic [31:0]      rbase;
    } slot_t;

    slot_t st_d, st_q;
    logic  sel_ok;

    always_comb begin
        st_d   = st_q;
        sel_ok = {1'b0, wdata_i[SEL_W-1:0]} < NC;
        if (sel_we_i && sel_ok) st_d.sel = wdata_i[IDX_W-1:0];
        if (rb_we_i) st_d.rbase = wdata_i[31:0] & RB_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel   <= '0;
            st_q.rbase <= RB_RESET & RB_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o   = st_q.sel;
    assign rbase_o = st_q.rbase;
    assign vec_o   = {{(DW-32){st_q.rbase[31]}}, st_q.rbase};

endmodule

// File: rtl/mcgr_sub_region.sv
module mcgr_sub_region #(
    parameter int          DW        = 64,
    parameter logic [31:0] ADDR_MASK = 32'hFFFF_8000,
    parameter int          EN_BIT    = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          present_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] stored_o,
    output logic [DW-1:0] base_o,
    output logic          en_o
);
    localparam logic [31:0] FULL_MASK = ADDR_MASK | (32'd1 << EN_BIT);

    logic [31:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we_i && present_i) val_d = wdata_i[31:0] & FULL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign stored_o = DW'(val_q);
    assign base_o   = DW'(val_q & ADDR_MASK);
    assign en_o     = val_q[EN_BIT];

endmodule

// File: rtl/mcgr_top.sv
module mcgr_top
    import mcgr_pkg::*;
#(
    parameter int          NCORES      = 4,
    parameter int          DW          = 64,
    parameter int          AW          = 16,
    parameter int          SEL_W       = 4,
    parameter logic [3:0]  LOC_WIN     = 4'h2,
    parameter logic [3:0]  OTH_WIN     = 4'h4,
    parameter logic [11:0] OFF_CFG     = 12'h000,
    parameter logic [11:0] OFF_BLK     = 12'h008,
    parameter logic [11:0] OFF_REV     = 12'h030,
    parameter logic [11:0] OFF_ICBASE  = 12'h080,
    parameter logic [11:0] OFF_PCBASE  = 12'h088,
    parameter logic [11:0] OFF_ICSTAT  = 12'h0D0,
    parameter logic [11:0] OFF_PCSTAT  = 12'h0F0,
    parameter logic [11:0] OFF_L2      = 12'h130,
    parameter logic [11:0] OFF_CCFG    = 12'h010,
    parameter logic [11:0] OFF_SEL     = 12'h018,
    parameter logic [11:0] OFF_RB      = 12'h020,
    parameter int          L2_BYP_BIT  = 20,
    parameter logic [31:0] REV         = 32'h0000_0800,
    parameter logic [31:0] BLK_BASE    = 32'h1FBF_8000,
    parameter logic [31:0] RB_MASK     = 32'hFFFF_F000,
    parameter logic [31:0] RB_RESET    = 32'hBFC0_0000,
    parameter logic [31:0] SUB_AMASK   = 32'hFFFF_8000,
    parameter int          SUB_EN_BIT  = 0,
    localparam int         IDX_W       = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int         WIN_BITS    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [IDX_W-1:0]     req_id_i,
    output logic [DW-1:0]        rdata_o,
    output logic [NCORES*DW-1:0] vec_o,
    input  logic                 ic_present_i,
    input  logic                 pc_present_i,
    output logic [DW-1:0]        ic_base_o,
    output logic                 ic_en_o,
    output logic [DW-1:0]        pc_base_o,
    output logic                 pc_en_o
);
    logic [IDX_W-1:0]        sel_a   [NCORES];
    logic [31:0]             rb_a    [NCORES];
    logic [NCORES*IDX_W-1:0] sel_flat;
    logic [IDX_W-1:0]        tgt;
    logic [WIN_BITS-1:0]     off;
    logic [AW-WIN_BITS-1:0]  win_id;
    win_e                    win;
    logic                    core_win;
    logic [DW-1:0]           ic_stored, pc_stored;
    logic                    ic_we, pc_we;

    assign off    = addr_i[WIN_BITS-1:0];
    assign win_id = addr_i[AW-1:WIN_BITS];

    always_comb begin
        if (win_id == '0)                                  win = WIN_GLOBAL;
        else if (win_id == (AW-WIN_BITS)'(LOC_WIN))        win = WIN_LOCAL;
        else if (win_id == (AW-WIN_BITS)'(OTH_WIN))        win = WIN_OTHER;
        else                                               win = WIN_NONE;
    end

    assign core_win = (win == WIN_LOCAL) || (win == WIN_OTHER);
    assign tgt      = (win == WIN_LOCAL) ? req_id_i : sel_a[req_id_i];

    generate
        for (genvar i = 0; i < NCORES; i++) begin : g_core
            logic sel_we, rb_we;
            assign sel_we = wr_en_i && core_win && off == OFF_SEL && tgt == IDX_W'(i);
            assign rb_we  = wr_en_i && core_win && off == OFF_RB  && tgt == IDX_W'(i);

            mcgr_core_slot #(
                .DW(DW), .NCORES(NCORES), .IDX_W(IDX_W), .SEL_W(SEL_W),
                .RB_MASK(RB_MASK), .RB_RESET(RB_RESET)
            ) u_slot (
                .clk(clk), .rst_n(rst_n),
                .sel_we_i(sel_we), .rb_we_i(rb_we), .wdata_i(wdata_i),
                .sel_o(sel_a[i]), .rbase_o(rb_a[i]),
                .vec_o(vec_o[i*DW +: DW])
            );
            assign sel_flat[i*IDX_W +: IDX_W] = sel_a[i];
        end
    endgenerate

    assign ic_we = wr_en_i && win == WIN_GLOBAL && off == OFF_ICBASE;
    assign pc_we = wr_en_i && win == WIN_GLOBAL && off == OFF_PCBASE;

    mcgr_sub_region #(.DW(DW), .ADDR_MASK(SUB_AMASK), .EN_BIT(SUB_EN_BIT)) u_ic (
        .clk(clk), .rst_n(rst_n), .present_i(ic_present_i), .we_i(ic_we),
        .wdata_i(wdata_i), .stored_o(ic_stored), .base_o(ic_base_o), .en_o(ic_en_o)
    );

    mcgr_sub_region #(.DW(DW), .ADDR_MASK(SUB_AMASK), .EN_BIT(SUB_EN_BIT)) u_pc (
        .clk(clk), .rst_n(rst_n), .present_i(pc_present_i), .we_i(pc_we),
        .wdata_i(wdata_i), .stored_o(pc_stored), .base_o(pc_base_o), .en_o(pc_en_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (win)
                WIN_GLOBAL: begin
                    if      (off == OFF_CFG)    rdata_o = '0;
                    else if (off == OFF_BLK)    rdata_o = DW'(BLK_BASE);
                    else if (off == OFF_REV)    rdata_o = DW'(REV);
                    else if (off == OFF_ICBASE) rdata_o = ic_stored;
                    else if (off == OFF_PCBASE) rdata_o = pc_stored;
                    else if (off == OFF_ICSTAT) rdata_o = DW'(ic_present_i);
                    else if (off == OFF_PCSTAT) rdata_o = DW'(pc_present_i);
                    else if (off == OFF_L2)     rdata_o = DW'(1) << L2_BYP_BIT;
                end
                WIN_LOCAL, WIN_OTHER: begin
                    if      (off == OFF_CCFG) rdata_o = DW'(NCORES - 1);
                    else if (off == OFF_SEL)  rdata_o = DW'(sel_a[tgt]);
                    else if (off == OFF_RB)   rdata_o = DW'(rb_a[tgt]);
                end
                default: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/mcgr_checker.sv
module mcgr_checker #(
    parameter int          NCORES     = 4,
    parameter int          DW         = 64,
    parameter int          AW         = 16,
    parameter int          IDX_W      = 2,
    parameter int          SEL_W      = 4,
    parameter logic [3:0]  LOC_WIN    = 4'h2,
    parameter logic [11:0] OFF_CFG    = 12'h000,
    parameter logic [11:0] OFF_ICBASE = 12'h080,
    parameter logic [11:0] OFF_ICSTAT = 12'h0D0,
    parameter logic [11:0] OFF_L2     = 12'h130,
    parameter logic [11:0] OFF_SEL    = 12'h018,
    parameter logic [11:0] OFF_RB     = 12'h020,
    parameter int          L2_BYP_BIT = 20,
    parameter logic [31:0] RB_MASK    = 32'hFFFF_F000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [AW-1:0]           addr_i,
    input logic [DW-1:0]           wdata_i,
    input logic                    wr_en_i,
    input logic                    rd_en_i,
    input logic [IDX_W-1:0]        req_id_i,
    input logic [DW-1:0]           rdata_o,
    input logic [NCORES*DW-1:0]    vec_o,
    input logic                    ic_present_i,
    input logic [DW-1:0]           ic_base_o,
    input logic                    ic_en_o,
    input logic [NCORES*IDX_W-1:0] sel_flat
);
    localparam logic [AW-1:0] LOC_BASE = AW'(LOC_WIN) << 12;

    logic          loc_sel_wr, loc_rb_wr, sel_bad;
    logic [DW-1:0] exp_vec;

    assign loc_sel_wr = wr_en_i && addr_i == (LOC_BASE | AW'(OFF_SEL));
    assign loc_rb_wr  = wr_en_i && addr_i == (LOC_BASE | AW'(OFF_RB));
    assign sel_bad    = {1'b0, wdata_i[SEL_W-1:0]} >= (SEL_W+1)'(NCORES);
    assign exp_vec    = {{(DW-32){wdata_i[31]}}, wdata_i[31:0] & RB_MASK};

    AST_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && addr_i == AW'(OFF_CFG) |-> rdata_o == '0); // R1

    AST_SEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        loc_sel_wr && sel_bad |=> $stable(sel_flat)); // R3

    generate
        for (genvar i = 0; i < NCORES; i++) begin : g_vec
            AST_VEC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
                loc_rb_wr && req_id_i == IDX_W'(i) |=> vec_o[i*DW +: DW] == $past(exp_vec)); // R6
        end
    endgenerate

    AST_SUB_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && addr_i == AW'(OFF_ICBASE) && !ic_present_i |=> $stable(ic_base_o) && $stable(ic_en_o)); // R7

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && addr_i == AW'(OFF_ICSTAT) |-> rdata_o == DW'(ic_present_i)); // R8

    AST_L2_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && addr_i == AW'(OFF_L2) |-> rdata_o == DW'(1) << L2_BYP_BIT); // R9

endmodule

bind mcgr_top mcgr_checker #(
    .NCORES(NCORES), .DW(DW), .AW(AW), .IDX_W(IDX_W), .SEL_W(SEL_W),
    .LOC_WIN(LOC_WIN), .OFF_CFG(OFF_CFG), .OFF_ICBASE(OFF_ICBASE),
    .OFF_ICSTAT(OFF_ICSTAT), .OFF_L2(OFF_L2), .OFF_SEL(OFF_SEL), .OFF_RB(OFF_RB),
    .L2_BYP_BIT(L2_BYP_BIT), .RB_MASK(RB_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .req_id_i(req_id_i),
    .rdata_o(rdata_o), .vec_o(vec_o), .ic_present_i(ic_present_i),
    .ic_base_o(ic_base_o), .ic_en_o(ic_en_o), .sel_flat(sel_flat)
);

// File: tb/tb_mcgr_top.sv
module tb_mcgr_top;
    localparam int DW = 64;

    localparam logic [15:0] A_CFG    = 16'h0000;
    localparam logic [15:0] A_BLK    = 16'h0008;
    localparam logic [15:0] A_REV    = 16'h0030;
    localparam logic [15:0] A_ICBASE = 16'h0080;
    localparam logic [15:0] A_PCBASE = 16'h0088;
    localparam logic [15:0] A_ICSTAT = 16'h00D0;
    localparam logic [15:0] A_PCSTAT = 16'h00F0;
    localparam logic [15:0] A_L2     = 16'h0130;
    localparam logic [15:0] L_CCFG   = 16'h2010;
    localparam logic [15:0] L_SEL    = 16'h2018;
    localparam logic [15:0] L_RB     = 16'h2020;
    localparam logic [15:0] O_CCFG   = 16'h4010;
    localparam logic [15:0] O_SEL    = 16'h4018;
    localparam logic [15:0] O_RB     = 16'h4020;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [15:0]   addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          wr_en_i = 0, rd_en_i = 0;
    logic [1:0]    req_id_i = '0;
    logic [DW-1:0] rdata_o;
    logic [4*DW-1:0] vec_o;
    logic          ic_present_i = 0, pc_present_i = 0;
    logic [DW-1:0] ic_base_o, pc_base_o;
    logic          ic_en_o, pc_en_o;

    int checks = 0;
    int errors = 0;

    mcgr_top dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .req_id_i(req_id_i),
        .rdata_o(rdata_o), .vec_o(vec_o),
        .ic_present_i(ic_present_i), .pc_present_i(pc_present_i),
        .ic_base_o(ic_base_o), .ic_en_o(ic_en_o),
        .pc_base_o(pc_base_o), .pc_en_o(pc_en_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [DW-1:0] d, input logic [1:0] id);
        @(negedge clk);
        addr_i = a; wdata_i = d; req_id_i = id; wr_en_i = 1;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] id, output logic [DW-1:0] v);
        @(negedge clk);
        addr_i = a; req_id_i = id; rd_en_i = 1;
        #1 v = rdata_o;
        rd_en_i = 0;
    endtask

    function automatic logic [DW-1:0] vec_of(input int c);
        return vec_o[c*DW +: DW];
    endfunction

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int c = 0; c < 4; c++) chk("R5 vector after reset", vec_of(c), 64'hFFFF_FFFF_BFC0_0000);
        rd(L_SEL, 2'd1, v);  chk("R5 selector after reset", v, 0);
        rd(L_RB, 2'd3, v);   chk("R5 reset base after reset", v, 64'hBFC0_0000);
        chk("R10 ic base after reset", ic_base_o, 0);
        chk("R10 ic enable after reset", DW'(ic_en_o), 0);
        chk("R10 pc base after reset", pc_base_o, 0);
        chk("R10 pc enable after reset", DW'(pc_en_o), 0);
    endtask

    task automatic t_global();
        logic [DW-1:0] v;
        rd(A_CFG, 2'd0, v); chk("R1 global config", v, 0);
        rd(A_REV, 2'd0, v); chk("R9 revision", v, 64'h800);
        rd(A_BLK, 2'd2, v); chk("R9 block base", v, 64'h1FBF_8000);
        rd(A_L2, 2'd1, v);  chk("R9 cache config", v, 64'h0010_0000);
    endtask

    task automatic t_core_cfg();
        logic [DW-1:0] v;
        rd(L_CCFG, 2'd2, v); chk("R2 core config local", v, 3);
        rd(O_CCFG, 2'd2, v); chk("R2 core config other", v, 3);
    endtask

    task automatic t_vector();
        wr(L_RB, 64'h0000_0000_1234_5FFF, 2'd1);
        chk("R6 positive vector", vec_of(1), 64'h0000_0000_1234_5000);
        chk("R6 other vector untouched", vec_of(0), 64'hFFFF_FFFF_BFC0_0000);
        wr(L_RB, 64'hAAAA_0000_8000_1ABC, 2'd3);
        chk("R6 sign extended vector", vec_of(3), 64'hFFFF_FFFF_8000_1000);
    endtask

    task automatic t_selector();
        logic [DW-1:0] v;
        wr(L_SEL, 64'd2, 2'd0);
        rd(L_SEL, 2'd0, v); chk("R3 in-range selector", v, 2);
        wr(L_SEL, 64'd5, 2'd0);
        rd(L_SEL, 2'd0, v); chk("R3 out-of-range 5 rejected", v, 2);
        wr(L_SEL, 64'd4, 2'd0);
        rd(L_SEL, 2'd0, v); chk("R3 out-of-range 4 rejected", v, 2);
        wr(L_SEL, 64'h13, 2'd1);
        rd(L_SEL, 2'd1, v); chk("R3 masked 0x13 accepted as 3", v, 3);
    endtask

    task automatic t_windows();
        logic [DW-1:0] v;
        // core 0 selects core 2 (set in t_selector)
        wr(O_RB, 64'h0040_0000, 2'd0);
        chk("R4 other window write lands on core 2", vec_of(2), 64'h0000_0000_0040_0000);
        chk("R4 requester vector untouched", vec_of(0), 64'hFFFF_FFFF_BFC0_0000);
        rd(O_RB, 2'd0, v); chk("R4 other window read", v, 64'h0040_0000);
        rd(O_SEL, 2'd0, v); chk("R4 other selector read", v, 0);
        wr(O_SEL, 64'd3, 2'd0);
        rd(L_SEL, 2'd2, v); chk("R4 other selector write", v, 3);
        rd(L_SEL, 2'd0, v); chk("R4 requester selector kept", v, 2);
        wr(O_SEL, 64'd9, 2'd0);
        rd(L_SEL, 2'd2, v); chk("R3 other window out-of-range", v, 3);
        rd(O_RB, 2'd1, v); chk("R4 core 1 other window to core 3", v, 64'h8000_1000);
    endtask

    task automatic t_sub();
        logic [DW-1:0] v;
        ic_present_i = 1; pc_present_i = 0;
        rd(A_ICSTAT, 2'd0, v); chk("R8 ic status present", v, 1);
        rd(A_PCSTAT, 2'd0, v); chk("R8 pc status absent", v, 0);
        wr(A_ICBASE, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
        chk("R7 ic base out", ic_base_o, 64'hFFFF_8000);
        chk("R7 ic enable out", DW'(ic_en_o), 1);
        rd(A_ICBASE, 2'd0, v); chk("R8 ic base readback", v, 64'hFFFF_8001);
        wr(A_PCBASE, 64'h1234_8001, 2'd0);
        chk("R7 absent pc base unchanged", pc_base_o, 0);
        chk("R7 absent pc enable unchanged", DW'(pc_en_o), 0);
        rd(A_PCBASE, 2'd0, v); chk("R7 absent pc readback", v, 0);
        pc_present_i = 1;
        wr(A_PCBASE, 64'h1234_FFFE, 2'd0);
        chk("R7 pc base out", pc_base_o, 64'h1234_8000);
        chk("R7 pc enable clear", DW'(pc_en_o), 0);
        rd(A_PCSTAT, 2'd0, v); chk("R8 pc status present", v, 1);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] v;
        wr(16'h0200, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
        rd(16'h0200, 2'd0, v); chk("R1 unmapped global read", v, 0);
        wr(16'h2F00, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1);
        wr(16'h8020, 64'h0, 2'd1);
        chk("R1 unmapped write leaves vector", vec_of(1), 64'h0000_0000_1234_5000);
        chk("R1 unmapped write leaves ic base", ic_base_o, 64'hFFFF_8000);
        rd(16'h2F00, 2'd1, v); chk("R1 unmapped window read", v, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_global();
        t_core_cfg();
        t_vector();
        t_selector();
        t_windows();
        t_sub();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule